// File: doc/BRIEF.md
# Way-Predicted Set-Associative Cache Read Path

This block is the read side of a small set-associative cache that bets on which way holds the requested line before the tags are compared. A per-set table remembers the way that was used most recently in each set. When a request is accepted, only that way's line storage is read and the output word select is set up for it. The tags of every way are read alongside for the compare, which runs in the following cycle. When the bet is right, the word comes out one cycle after acceptance.

When the bet is wrong but another way holds the line, the speculative word is withdrawn with a cancel pulse. The way that really matched is then read in a second cycle. When no way holds the line, the block raises a line request toward memory and waits for a whole-line refill. It writes the refill into a victim way picked by a per-set round-robin pointer, then returns the requested word. Only one request is in flight at a time.

Top module: `wpred_cache`

## Requirements
- R1: A 32-bit address is split into a 24-bit tag (bits 31:8), a 4-bit set number (bits 7:4), a 2-bit word number (bits 3:2) and an unused byte position (bits 1:0). The returned word is word number n of the line, which is refill_data bits [32n+31:32n].
- R2: After reset, req_ready is high, rd_valid, rd_cancel and mem_req_valid are low, every line is invalid and every set predicts way 0.
- R3: When the predicted way holds the line, rd_valid is high with the correct word in the first cycle after the acceptance edge, and rd_cancel stays low. In that cycle only one way's line storage has been read.
- R4: When another way holds the line, rd_cancel pulses in the first cycle after acceptance with rd_valid low, and rd_valid with the correct word follows in the second cycle.
- R5: When no way holds the line, rd_cancel pulses in the first cycle. mem_req_valid rises in the second cycle with mem_req_addr set to the line address (bits 3:0 zero). Both stay unchanged until refill_valid is sampled high.
- R6: After the edge that samples refill_valid, mem_req_valid falls, and rd_valid with the requested word from the new line appears in the second cycle after that edge.
- R7: Every hit and every refill sets the set's prediction to the way involved, so that the next read of the same line in that set is a correct prediction.
- R8: Refills within one set replace ways 0, 1, 2, 3, 0, … in turn, independently of other sets, so that the fifth distinct line in a set evicts the first.
- R9: req_ready is low from the cycle after acceptance until the request completes. A req_valid seen while req_ready is low produces no response.
- R10: refill_valid is ignored unless a line request is outstanding: it changes no stored line and raises no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Read byte address |
| req_ready | output | 1 | Block can accept a request this cycle |
| rd_valid | output | 1 | rd_data holds the requested word |
| rd_data | output | 32 | Returned word |
| rd_cancel | output | 1 | Speculative result of the first cycle is withdrawn |
| mem_req_valid | output | 1 | Line fetch request toward memory |
| mem_req_addr | output | 32 | Line-aligned address of the fetch |
| refill_valid | input | 1 | Refill line present |
| refill_data | input | 128 | Whole refill line, word 0 in the low bits |

## Verification
A corrupted prediction entry shows up at the ports one cycle after the next acceptance in that set: a read that should be a quick hit produces a cancel pulse and arrives a cycle late, or a cancel appears where none was due. A wrong round-robin pointer or valid bit shows up later, when a line that should still be resident misses, or when a line that should have been evicted still hits. That shows only when the set fills past four lines, so the sequence drives one set through two full rounds. A wrong way selection on the reread or the refill path shows at once as a wrong word on the rd_valid cycle.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,  // waiting for a request
    S_LOOK = 3'd1,  // tags compared, speculative word on the output
    S_FIX  = 3'd2,  // corrected word on the output
    S_MISS = 3'd3,  // line request outstanding
    S_FILL = 3'd4   // refilled line being read back
  } rd_state_e;
endpackage

// File: rtl/wpc_way_bank.sv
// One way: tag storage, valid bits and line storage, each read synchronously.
module wpc_way_bank #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 24,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tag_rd_en,
  input  logic [IDX_W-1:0]  tag_rd_idx,
  output logic [TAG_W-1:0]  tag_q,
  output logic              vld_q,
  input  logic              dat_rd_en,
  input  logic [IDX_W-1:0]  dat_rd_idx,
  output logic [LINE_W-1:0] line_q,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];
  logic [SETS-1:0]   vld_bits;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (tag_rd_en) tag_q <= tag_mem[tag_rd_idx];
  end

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[wr_idx] <= wr_line;
    if (dat_rd_en) line_q <= line_mem[dat_rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_bits <= '0;
      vld_q    <= 1'b0;
    end else begin
      if (wr_en) vld_bits[wr_idx] <= 1'b1;
      if (tag_rd_en) vld_q <= vld_bits[tag_rd_idx];
    end
  end
endmodule

// File: rtl/wpc_tag_match.sv
// Compares the registered tags of all ways against the request tag.
module wpc_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            vld,
  input  logic [TAG_W-1:0]           cmp_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit_any,
  output logic [WAY_W-1:0]           hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld[w] && (tags[w] == cmp_tag);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wpc_pred_table.sv
// Per-set predicted way and per-set round-robin victim pointer.
module wpc_pred_table #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  output logic [WAY_W-1:0] look_way,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [WAY_W-1:0] upd_way,
  input  logic [IDX_W-1:0] vic_idx,
  output logic [WAY_W-1:0] vic_way,
  input  logic             vic_adv
);
  logic [WAY_W-1:0] guess [SETS];
  logic [WAY_W-1:0] rr    [SETS];

  assign look_way = guess[look_idx];
  assign vic_way  = rr[vic_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        guess[s] <= '0;
        rr[s]    <= '0;
      end
    end else begin
      if (upd_en)  guess[upd_idx] <= upd_way;
      if (vic_adv) rr[vic_idx]    <= (rr[vic_idx] == WAY_W'(WAYS - 1)) ? '0 : rr[vic_idx] + 1'b1;
    end
  end
endmodule

// File: rtl/wpred_cache.sv
module wpred_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  parameter int LINE_BYTES = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      req_ready,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_cancel,
  output logic                      mem_req_valid,
  output logic [ADDR_W-1:0]         mem_req_addr,
  input  logic                      refill_valid,
  input  logic [LINE_BYTES*8-1:0]   refill_data
);
  import wpc_pkg::*;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WPL    = LINE_W / DATA_W;
  localparam int WSEL_W = $clog2(WPL);
  localparam int BSEL_W = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WSEL_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[BSEL_W +: WSEL_W];
  endfunction

  rd_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [WAY_W-1:0]  pred_q, out_way_q, fix_way_q;
  logic              mreq_q;

  logic [WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [WAYS-1:0]             vld_q;
  logic [LINE_W-1:0]           line_q [WAYS];
  logic [WAYS-1:0]             way_rd_en, way_wr_en;
  logic [WAYS-1:0]             hit_vec;
  logic                        hit_any;
  logic [WAY_W-1:0]            hit_way, pred_way, victim;

  logic accept, pred_ok, fix_rd, miss_now, fill_now;
  logic [IDX_W-1:0] dat_idx;
  logic [LINE_W-1:0] line_sel;

  assign accept   = req_valid && (state_q == S_IDLE);
  assign pred_ok  = hit_vec[pred_q];
  assign fix_rd   = (state_q == S_LOOK) && hit_any && !pred_ok;
  assign miss_now = (state_q == S_LOOK) && !hit_any;
  assign fill_now = (state_q == S_MISS) && refill_valid;
  assign dat_idx  = accept ? idx_of(req_addr) : idx_of(addr_q);

  wpc_pred_table #(.SETS(SETS), .WAYS(WAYS)) u_pred (
    .clk      (clk),
    .rst      (rst),
    .look_idx (idx_of(req_addr)),
    .look_way (pred_way),
    .upd_en   (((state_q == S_LOOK) && hit_any) || fill_now),
    .upd_idx  (idx_of(addr_q)),
    .upd_way  (fill_now ? victim : hit_way),
    .vic_idx  (idx_of(addr_q)),
    .vic_way  (victim),
    .vic_adv  (fill_now)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_rd_en[w] = (accept && (pred_way == WAY_W'(w)))
                       || (fix_rd && (hit_way == WAY_W'(w)))
                       || ((state_q == S_FILL) && (fix_way_q == WAY_W'(w)));
    assign way_wr_en[w] = fill_now && (victim == WAY_W'(w));

    wpc_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .tag_rd_en  (accept),
      .tag_rd_idx (idx_of(req_addr)),
      .tag_q      (tag_q[w]),
      .vld_q      (vld_q[w]),
      .dat_rd_en  (way_rd_en[w]),
      .dat_rd_idx (dat_idx),
      .line_q     (line_q[w]),
      .wr_en      (way_wr_en[w]),
      .wr_idx     (idx_of(addr_q)),
      .wr_tag     (tag_of(addr_q)),
      .wr_line    (refill_data)
    );
  end

  wpc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags    (tag_q),
    .vld     (vld_q),
    .cmp_tag (tag_of(addr_q)),
    .hit_vec (hit_vec),
    .hit_any (hit_any),
    .hit_way (hit_way)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (req_valid) state_d = S_LOOK;
      S_LOOK:  if (pred_ok) state_d = S_IDLE;
               else if (hit_any) state_d = S_FIX;
               else state_d = S_MISS;
      S_MISS:  if (refill_valid) state_d = S_FILL;
      S_FILL:  state_d = S_FIX;
      S_FIX:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      addr_q    <= '0;
      pred_q    <= '0;
      out_way_q <= '0;
      fix_way_q <= '0;
      mreq_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q    <= req_addr;
        pred_q    <= pred_way;
        out_way_q <= pred_way;
      end
      if (fix_rd) out_way_q <= hit_way;
      if (state_q == S_FILL) out_way_q <= fix_way_q;
      if (fill_now) fix_way_q <= victim;
      if (miss_now) mreq_q <= 1'b1;
      else if (fill_now) mreq_q <= 1'b0;
    end
  end

  assign line_sel      = line_q[out_way_q];
  assign rd_data       = line_sel[int'(word_of(addr_q)) * DATA_W +: DATA_W];
  assign rd_valid      = ((state_q == S_LOOK) && pred_ok) || (state_q == S_FIX);
  assign rd_cancel     = (state_q == S_LOOK) && !pred_ok;
  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = mreq_q;
  assign mem_req_addr  = addr_q & ~OFF_MASK;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              rd_cancel,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              refill_valid,
  input logic [WAYS-1:0]   way_rd_en
);
  // R3: at most one way's line storage is read in any cycle
  a_r3_single_way_read: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_rd_en));

  // R3 / R4: a word is never delivered and withdrawn together
  a_r4_valid_cancel_excl: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_cancel));

  // R9: acceptance closes the input and yields a result or a cancel next cycle
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && (rd_valid || rd_cancel)));

  // R4 / R5: a cancel is followed by the reread word or a line request
  a_r4_cancel_followup: assert property (@(posedge clk) disable iff (rst)
    rd_cancel |=> (rd_valid || mem_req_valid));

  // R5: the line request holds still until the refill arrives
  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !refill_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R6: the line request drops once the refill is taken
  a_r6_req_drops: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && refill_valid) |=> !mem_req_valid);

  // R9: one request yields one delivered word
  a_r9_single_result: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

bind wpred_cache wpc_checker #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rd_valid      (rd_valid),
  .rd_cancel     (rd_cancel),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .refill_valid  (refill_valid),
  .way_rd_en     (way_rd_en)
);

// File: tb/wpred_cache_bench.sv
module wpred_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_HIT = 2'd0, K_MISP = 2'd1, K_MISS = 2'd2;

  function automatic logic [31:0] mk(input int tag, input int set, input int word);
    return {tag[23:0], set[3:0], word[1:0], 2'b00};
  endfunction

  function automatic logic [31:0] line_word(input logic [31:0] line_addr, input int w);
    return (line_addr ^ 32'hC3A5_0F00) + 32'(w * 32'h0101_0011);
  endfunction

  // {kind, address}; kinds worked out from R3, R4, R5, R7, R8
  localparam int NV = 16;
  localparam logic [33:0] VEC [NV] = '{
    {K_MISS, mk(1, 0, 0)},  // fills set0 way0
    {K_HIT,  mk(1, 0, 2)},
    {K_MISS, mk(2, 0, 1)},  // way1, prediction -> 1
    {K_MISP, mk(1, 0, 3)},  // tag1 is in way0
    {K_HIT,  mk(1, 0, 1)},
    {K_MISP, mk(2, 0, 0)},
    {K_MISS, mk(3, 0, 0)},  // way2
    {K_MISS, mk(4, 0, 0)},  // way3
    {K_MISS, mk(5, 0, 0)},  // way0, evicts tag1
    {K_MISS, mk(1, 0, 0)},  // way1, evicts tag2
    {K_MISP, mk(3, 0, 2)},
    {K_MISS, mk(7, 5, 1)},  // set5 has its own pointer: way0
    {K_HIT,  mk(7, 5, 3)},
    {K_MISS, mk(2, 0, 0)},  // way2, evicts tag3
    {K_MISS, mk(3, 0, 0)},  // way3, evicts tag4
    {K_MISP, mk(5, 0, 3)}   // tag5 still in way0
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic         req_ready, rd_valid, rd_cancel, mem_req_valid;
  logic [31:0]  rd_data, mem_req_addr;
  logic         refill_valid = 1'b0;
  logic [127:0] refill_data = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wpred_cache u_wpred_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_cancel(rd_cancel), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .refill_valid(refill_valid),
    .refill_data(refill_data)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [127:0] make_line(input logic [31:0] la);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = line_word(la, w);
    return l;
  endfunction

  // Issue one read and check its timing and word; samples at negedges.
  task automatic do_read(input logic [31:0] a, input logic [1:0] kind, input int delay,
                         input bit glitch);
    logic [31:0] la;
    logic [31:0] exp_w;
    la    = a & 32'hFFFF_FFF0;
    exp_w = line_word(la, int'(a[3:2]));
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 ready low after accept", 32'(req_ready), 32'd0);
    if (kind == K_HIT) begin
      chk("R3/R7 valid cycle1", 32'(rd_valid), 32'd1);
      chk("R3 no cancel", 32'(rd_cancel), 32'd0);
      chk("R1/R3 data", rd_data, exp_w);
    end else begin
      chk("R4/R5 cancel cycle1", 32'(rd_cancel), 32'd1);
      chk("R4/R5 no valid cycle1", 32'(rd_valid), 32'd0);
      @(negedge clk);
      if (kind == K_MISP) begin
        chk("R4 valid cycle2", 32'(rd_valid), 32'd1);
        chk("R1/R4 data", rd_data, exp_w);
      end else begin
        chk("R5 mem req", 32'(mem_req_valid), 32'd1);
        chk("R5 line addr", mem_req_addr, la);
        if (glitch) begin  // R9: request while busy must be ignored
          req_valid = 1'b1;
          req_addr  = mk(12, 9, 1);
        end
        for (int d = 0; d < delay; d++) begin
          @(negedge clk);
          req_valid = 1'b0;
          chk("R5 req held", 32'(mem_req_valid), 32'd1);
          chk("R5 addr held", mem_req_addr, la);
        end
        req_valid    = 1'b0;
        refill_valid = 1'b1;
        refill_data  = make_line(la);
        @(posedge clk);
        @(negedge clk);
        refill_valid = 1'b0;
        refill_data  = '0;
        chk("R6 req dropped", 32'(mem_req_valid), 32'd0);
        chk("R6 no valid yet", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk("R6 valid after fill", 32'(rd_valid), 32'd1);
        chk("R1/R6/R8 data", rd_data, exp_w);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    chk("R2 ready", 32'(req_ready), 32'd1);
    chk("R2 valid", 32'(rd_valid), 32'd0);
    chk("R2 cancel", 32'(rd_cancel), 32'd0);
    chk("R2 mem req", 32'(mem_req_valid), 32'd0);

    for (int i = 0; i < NV; i++)
      do_read(VEC[i][31:0], VEC[i][33:32], i % 4, 1'b0);

    // R10: stray refill with no request outstanding
    @(negedge clk);
    refill_valid = 1'b1;
    refill_data  = {4{32'hDEAD_BEEF}};
    @(negedge clk);
    refill_valid = 1'b0;
    chk("R10 no mem req", 32'(mem_req_valid), 32'd0);
    chk("R10 no valid", 32'(rd_valid), 32'd0);
    do_read(mk(5, 0, 3), K_HIT, 0, 1'b0);   // R10 line unchanged, R7 prediction 0
    do_read(mk(5, 0, 1), K_HIT, 0, 1'b0);

    // R9: request raised while busy produces nothing
    do_read(mk(9, 3, 0), K_MISS, 2, 1'b1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R9 no extra valid", 32'(rd_valid), 32'd0);
      chk("R9 no extra cancel", 32'(rd_cancel), 32'd0);
      chk("R9 no extra mem req", 32'(mem_req_valid), 32'd0);
    end
    do_read(mk(9, 3, 2), K_HIT, 0, 1'b0);   // R7
    do_read(mk(12, 9, 1), K_MISS, 0, 1'b0); // R9 ignored address never filled

    // R2: reset again restores invalid lines and way-0 prediction
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R2 ready after reset", 32'(req_ready), 32'd1);
    do_read(mk(9, 3, 2), K_MISS, 1, 1'b0);  // R2 lines invalid after reset

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule